// File: doc/BRIEF.md
# Odd-Weight-Column SEC-DED Codec

This block guards a data word with a systematic single-error-correcting, double-error-detecting code. Every column of its parity-check matrix has odd weight. A combinational encode path appends R check bits to K data bits. A registered decode path takes a received word of N = K + R bits and works out its syndrome. It repairs any one flipped bit and reports words it cannot repair. The matrix is built during elaboration from the parameters, so the same source covers the default 8+5 layout and the small 3+4 layout.

In the decoder, a zero syndrome means the word passes through unchanged. A syndrome that equals a matrix column points at one bit, and that bit is inverted. Any other nonzero syndrome raises the uncorrectable flag and leaves the data untouched. Any two flipped bits give an even-weight syndrome, so they are never taken for a single error.

Top module: `secded_codec`

## Requirements
- R1: The codeword is systematic: bits [N-1:R] of `enc_code` equal `enc_data`, and the check bits occupy bits [R-1:0].
- R2: Check bit i is the XOR of the data bits whose matrix column has row i set. The column for codeword bit p < R is the weight-1 value 1<<p. Data bit j takes the j-th value from the list of all R-bit values of weight 3, then weight 5, and so on, each weight group in ascending numeric order. With the defaults, data 8'h01 gives check 5'b00111 and data 8'h80 gives check 5'b11001.
- R3: A received word with a zero syndrome is returned with its data unchanged, and neither error flag is set.
- R4: A single flipped data bit is corrected. The decoder returns the original data, sets `dec_single`, and reports that bit's column as the syndrome.
- R5: A single flipped check bit leaves the data output equal to the original data. It sets `dec_single`, and the syndrome is 1<<p for flipped bit p.
- R6: Any two flipped bits set `dec_double`, clear `dec_single`, and return the received data bits without correction. More generally, a nonzero syndrome that matches no column is handled the same way.
- R7: `dec_syndrome` equals the XOR of the columns of all flipped bits.
- R8: Decode results appear one clock after `dec_in_valid` is sampled high. `dec_out_valid` is the one-cycle-delayed copy of `dec_in_valid`.
- R9: While reset is asserted (rst_n low), `dec_out_valid`, `dec_single` and `dec_double` are 0.
- R10: `dec_single` and `dec_double` are never both 1.
- R11: The parameter set K=3, R=4 is supported. Its data columns are 4'b0111, 4'b1011 and 4'b1101 for data bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data | input | K | Data word to encode |
| enc_code | output | K+R | Codeword: data on top, check bits below |
| dec_in_valid | input | 1 | Received word is present |
| dec_code | input | K+R | Received word |
| dec_out_valid | output | 1 | Decode result is present |
| dec_data | output | K | Corrected or passed-through data |
| dec_single | output | 1 | One bit was corrected |
| dec_double | output | 1 | Uncorrectable error detected |
| dec_syndrome | output | R | Raw syndrome of the received word |

## Verification
Some properties are checked by assertions on every cycle: the valid flag follows the input one clock later, the two flags are never both set, a zero syndrome never raises a flag, and an even nonzero syndrome always raises the uncorrectable flag. Another assertion shows that at most one data bit is ever inverted. Only the bench's scenarios can show that the inverted bit is the right one and that each check bit has the right matrix column. To do this, the bench injects every single flip and every pair of flips on several data words, in both parameter sets, and compares the results against an independent model of the matrix.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int MAX_R = 16;
  localparam int MAX_K = 64;

  typedef logic [MAX_R-1:0] col_t;
  typedef logic [MAX_K-1:0] mask_t;

  // population count of a column value
  function automatic int weight_of(col_t v);
    int n;
    n = 0;
    for (int b = 0; b < MAX_R; b++) n += int'(v[b]);
    return n;
  endfunction

  // column of the parity-check matrix for codeword bit pos
  // pos < r : check bit, weight-1 column
  // pos >= r: data bit pos-r, odd weights >= 3 taken lightest first,
  //           ascending value within a weight group
  function automatic col_t column_of(int r, int pos);
    col_t res;
    int   seen;
    int   want;
    res  = '0;
    seen = 0;
    if (pos < r) begin
      res = col_t'(1) << pos;
    end else begin
      want = pos - r;
      for (int w = 3; w <= r; w += 2) begin
        for (int v = 1; v < (1 << r); v++) begin
          if (weight_of(col_t'(v)) == w) begin
            if (seen == want) res = col_t'(v);
            seen++;
          end
        end
      end
    end
    return res;
  endfunction

  // how many data columns the construction can supply for r rows
  function automatic int data_capacity(int r);
    int n;
    n = 0;
    for (int v = 1; v < (1 << r); v++) begin
      if (weight_of(col_t'(v)) >= 3 && weight_of(col_t'(v)) % 2 == 1) n++;
    end
    return n;
  endfunction

  // data bits feeding check row `row`
  function automatic mask_t row_taps(int r, int k, int row);
    mask_t m;
    col_t  c;
    m = '0;
    for (int j = 0; j < k; j++) begin
      c    = column_of(r, r + j);
      m[j] = c[row];
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int K = 8,
  parameter int R = 5
) (
  input  logic [K-1:0] data_i,
  output logic [R-1:0] check_o
);

  for (genvar i = 0; i < R; i++) begin : g_row
    localparam mask_t FULL = row_taps(R, K, i);
    localparam logic [K-1:0] TAPS = FULL[K-1:0];
    assign check_o[i] = ^(data_i & TAPS);
  end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter int K = 8,
  parameter int R = 5
) (
  input  logic [K-1:0] rx_data_i,
  input  logic [R-1:0] rx_check_i,
  output logic [R-1:0] syndrome_o
);

  logic [R-1:0] recomputed;

  secded_encoder #(.K(K), .R(R)) u_regen (
    .data_i  (rx_data_i),
    .check_o (recomputed)
  );

  assign syndrome_o = recomputed ^ rx_check_i;

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
#(
  parameter int K = 8,
  parameter int R = 5
) (
  input  logic [R-1:0] syndrome_i,
  input  logic [K-1:0] rx_data_i,
  output logic [K-1:0] data_o,
  output logic [K-1:0] flip_mask_o,
  output logic         check_hit_o,
  output logic         single_o,
  output logic         double_o
);

  for (genvar j = 0; j < K; j++) begin : g_col
    localparam col_t CF = column_of(R, R + j);
    assign flip_mask_o[j] = (syndrome_i == CF[R-1:0]);
  end

  // weight-1 syndrome: the fault sits in a check bit, data is intact
  assign check_hit_o = $onehot(syndrome_i);
  assign single_o    = (|flip_mask_o) | check_hit_o;
  assign double_o    = (|syndrome_i) & ~single_o;
  assign data_o      = rx_data_i ^ flip_mask_o;

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int K = 8,
  parameter int R = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K-1:0]     enc_data,
  output logic [K+R-1:0]   enc_code,
  input  logic             dec_in_valid,
  input  logic [K+R-1:0]   dec_code,
  output logic             dec_out_valid,
  output logic [K-1:0]     dec_data,
  output logic             dec_single,
  output logic             dec_double,
  output logic [R-1:0]     dec_syndrome
);

  localparam int N   = K + R;
  localparam int CAP = data_capacity(R);

  if (K < 1 || K > CAP || R > MAX_R || K > MAX_K) begin : g_bad_params
    $error("secded_codec: K exceeds the odd-weight column supply of R");
  end

  // ---------------- encode path (combinational) ----------------
  logic [R-1:0] enc_check;

  secded_encoder #(.K(K), .R(R)) u_enc (
    .data_i  (enc_data),
    .check_o (enc_check)
  );

  assign enc_code = {enc_data, enc_check};

  // ---------------- decode path ----------------
  logic [K-1:0] rx_data;
  logic [R-1:0] rx_check;
  logic [R-1:0] syn_now;
  logic [K-1:0] fixed_data;
  logic [K-1:0] flip_mask;
  logic         check_hit;
  logic         single_now;
  logic         double_now;

  assign rx_data  = dec_code[N-1:R];
  assign rx_check = dec_code[R-1:0];

  secded_syndrome #(.K(K), .R(R)) u_syn (
    .rx_data_i  (rx_data),
    .rx_check_i (rx_check),
    .syndrome_o (syn_now)
  );

  secded_corrector #(.K(K), .R(R)) u_fix (
    .syndrome_i  (syn_now),
    .rx_data_i   (rx_data),
    .data_o      (fixed_data),
    .flip_mask_o (flip_mask),
    .check_hit_o (check_hit),
    .single_o    (single_now),
    .double_o    (double_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_out_valid <= 1'b0;
      dec_data      <= '0;
      dec_single    <= 1'b0;
      dec_double    <= 1'b0;
      dec_syndrome  <= '0;
    end else begin
      dec_out_valid <= dec_in_valid;
      if (dec_in_valid) begin
        dec_data     <= fixed_data;
        dec_single   <= single_now;
        dec_double   <= double_now;
        dec_syndrome <= syn_now;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid |=> dec_out_valid);

  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_valid |=> !dec_out_valid);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single && dec_double));

  a_r3_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_syndrome == '0) |-> (!dec_single && !dec_double));

  a_r6_even_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_syndrome != '0 && !(^dec_syndrome)) |-> dec_double);

  a_r4_single_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_single) |-> (^dec_syndrome));

  a_r4_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flip_mask));

  a_r5_check_hit_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    check_hit |-> (flip_mask == '0));

endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

  localparam int K  = 8;
  localparam int R  = 5;
  localparam int N  = K + R;
  localparam int KS = 3;
  localparam int RS = 4;
  localparam int NS = KS + RS;

  typedef struct {
    int    data;
    bit    single;
    bit    dbl;
    int    syn;
    string req;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [K-1:0]   enc_data = '0;
  logic [N-1:0]   enc_code;
  logic           dec_in_valid = 1'b0;
  logic [N-1:0]   dec_code = '0;
  logic           dec_out_valid;
  logic [K-1:0]   dec_data;
  logic           dec_single;
  logic           dec_double;
  logic [R-1:0]   dec_syndrome;

  logic [KS-1:0]  s_enc_data = '0;
  logic [NS-1:0]  s_enc_code;
  logic           s_in_valid = 1'b0;
  logic [NS-1:0]  s_code = '0;
  logic           s_out_valid;
  logic [KS-1:0]  s_data;
  logic           s_single;
  logic           s_double;
  logic [RS-1:0]  s_syn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  secded_codec #(.K(K), .R(R)) u_secded_codec (
    .clk, .rst_n, .enc_data, .enc_code, .dec_in_valid, .dec_code,
    .dec_out_valid, .dec_data, .dec_single, .dec_double, .dec_syndrome
  );

  secded_codec #(.K(KS), .R(RS)) u_secded_codec_small (
    .clk, .rst_n,
    .enc_data (s_enc_data), .enc_code (s_enc_code),
    .dec_in_valid (s_in_valid), .dec_code (s_code),
    .dec_out_valid (s_out_valid), .dec_data (s_data),
    .dec_single (s_single), .dec_double (s_double), .dec_syndrome (s_syn)
  );

  // ---------- independent model of the matrix ----------
  function automatic int popc(int v);
    int n = 0;
    while (v != 0) begin
      v = v & (v - 1);
      n++;
    end
    return n;
  endfunction

  function automatic int mcol(int r, int pos);
    int idx;
    if (pos < r) return 1 << pos;
    idx = pos - r;
    for (int w = 3; w <= r; w += 2)
      for (int v = 0; v < (1 << r); v++)
        if (popc(v) == w) begin
          if (idx == 0) return v;
          idx--;
        end
    return 0;
  endfunction

  function automatic int mcheck(int r, int k, int d);
    int acc = 0;
    for (int j = 0; j < k; j++)
      if (((d >> j) & 1) != 0) acc ^= mcol(r, r + j);
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------- driver ----------
  task automatic send(int code, exp_t e);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_code     = N'(code);
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_in_valid = 1'b0;
    end
  endtask

  // ---------- monitor ----------
  always @(negedge clk) begin
    if (rst_n && dec_out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "out_valid without request", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(dec_data) == e.data, e.req, "data", int'(dec_data), e.data);
        check(dec_single == e.single, e.req, "single", int'(dec_single), int'(e.single));
        check(dec_double == e.dbl, e.req, "double", int'(dec_double), int'(e.dbl));
        check(int'(dec_syndrome) == e.syn, e.req, "syndrome (R7)", int'(dec_syndrome), e.syn);
      end
    end
  end

  // ---------- watchdog ----------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------- main ----------
  initial begin
    int words[6];
    words[0] = 8'h00;
    words[1] = 8'hFF;
    words[2] = 8'hA5;
    words[3] = int'($urandom) & 8'hFF;
    words[4] = int'($urandom) & 8'hFF;
    words[5] = int'($urandom) & 8'hFF;

    repeat (3) @(negedge clk);
    // R9: outputs quiet under reset
    check(dec_out_valid == 1'b0, "R9", "out_valid in reset", int'(dec_out_valid), 0);
    check(!dec_single && !dec_double, "R9", "flags in reset",
          int'({dec_single, dec_double}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 anchors from the column order
    enc_data = 8'h01; #1;
    check(int'(enc_code[R-1:0]) == 5'b00111, "R2", "check of 0x01", int'(enc_code[R-1:0]), 5'b00111);
    enc_data = 8'h80; #1;
    check(int'(enc_code[R-1:0]) == 5'b11001, "R2", "check of 0x80", int'(enc_code[R-1:0]), 5'b11001);

    foreach (words[w]) begin
      int d;
      int code;
      d = words[w];
      @(negedge clk);
      enc_data = K'(d);
      #1;
      check(int'(enc_code[N-1:R]) == d, "R1", "data field", int'(enc_code[N-1:R]), d);
      check(int'(enc_code[R-1:0]) == mcheck(R, K, d), "R2", "check field",
            int'(enc_code[R-1:0]), mcheck(R, K, d));
      code = (d << R) | mcheck(R, K, d);

      send(code, '{data: d, single: 1'b0, dbl: 1'b0, syn: 0, req: "R3"});
      for (int p = 0; p < N; p++)
        send(code ^ (1 << p), '{data: d, single: 1'b1, dbl: 1'b0,
             syn: mcol(R, p), req: (p < R) ? "R5" : "R4"});
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++) begin
          int bad;
          bad = code ^ (1 << a) ^ (1 << b);
          send(bad, '{data: (bad >> R) & ((1 << K) - 1), single: 1'b0, dbl: 1'b1,
               syn: mcol(R, a) ^ mcol(R, b), req: "R6"});
        end
      idle(2);
    end

    // R8: valid drops after the stream stops
    idle(3);
    check(dec_out_valid == 1'b0, "R8", "out_valid idle", int'(dec_out_valid), 0);
    check(q.size() == 0, "R8", "pending results", q.size(), 0);

    // R11: small parameter set
    s_enc_data = 3'b001; #1;
    check(int'(s_enc_code[RS-1:0]) == 4'b0111, "R11", "small col 0", int'(s_enc_code[RS-1:0]), 4'b0111);
    s_enc_data = 3'b010; #1;
    check(int'(s_enc_code[RS-1:0]) == 4'b1011, "R11", "small col 1", int'(s_enc_code[RS-1:0]), 4'b1011);
    s_enc_data = 3'b100; #1;
    check(int'(s_enc_code[RS-1:0]) == 4'b1101, "R11", "small col 2", int'(s_enc_code[RS-1:0]), 4'b1101);
    for (int d = 0; d < 8; d++) begin
      s_enc_data = KS'(d); #1;
      check(int'(s_enc_code) == ((d << RS) | mcheck(RS, KS, d)), "R11", "small encode",
            int'(s_enc_code), (d << RS) | mcheck(RS, KS, d));
    end
    for (int p = 0; p < NS; p++) begin
      int code;
      code = (5 << RS) | mcheck(RS, KS, 5);
      @(negedge clk);
      s_in_valid = 1'b1;
      s_code     = NS'(code ^ (1 << p));
      @(negedge clk);
      s_in_valid = 1'b0;
      check(s_out_valid && int'(s_data) == 5 && s_single && !s_double, "R11",
            "small single fix", int'({s_out_valid, s_data, s_single, s_double}),
            int'({1'b1, 3'd5, 1'b1, 1'b0}));
      check(int'(s_syn) == mcol(RS, p), "R11", "small syndrome", int'(s_syn), mcol(RS, p));
    end
    begin
      int code;
      code = (5 << RS) | mcheck(RS, KS, 5);
      @(negedge clk);
      s_in_valid = 1'b1;
      s_code     = NS'(code ^ 7'b1000001);
      @(negedge clk);
      s_in_valid = 1'b0;
      check(s_double && !s_single && int'(s_data) == 1, "R11", "small double",
            int'({s_data, s_single, s_double}), int'({3'd1, 1'b0, 1'b1}));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule